// File: doc/BRIEF.md
# Ten-Bit Serial Transmitter with Sync Qualification

This block turns a 10-bit parallel word into a framed serial bit stream. A word is taken from the parallel bus on one edge of a word-rate clock. A run-time select input chooses whether that edge is the rising or the falling one. The word goes out as a 12-bit frame: a leading 1, the ten data bits with the least significant bit first, then a trailing 0. A bit-rate enable pulse, standing in for a multiplying PLL, moves the stream forward one bit per pulse.

Two synchronization request inputs are ORed together. When the combined request has been high across five selected word-clock edges, each new frame carries a fixed synchronization pattern in place of data. The pattern repeats for as long as the request stays high. A pattern that has begun is always sent to the end.

An output enable and an active-low powerdown control the drive-enable flag, which stands in for a tri-state driver. Powerdown also returns all internal state to idle. Everything runs on one fast system clock. The word clock is sampled as a data signal.

Top module: `ser10_tx`

## Requirements
- R1: A 10-bit word on `din` is stored as a unit on a selected edge of `word_clk`. With `edge_sel`=1 the selected edge is low-to-high; with `edge_sel`=0 it is high-to-low. A transition the other way leaves the stored word unchanged.
- R2: A frame is 12 bits, one per `bit_en` pulse. The first frame loads on the first `bit_en` after reset or powerdown. Frame bit 0 is 1, bits 1 to 10 are the data bits sent LSB first, and bit 11 is 0. Each bit appears on `ser_out` on the clock edge that samples its `bit_en` pulse.
- R3: A data frame carries the word that was stored at the moment the frame loads.
- R4: The combined request is `sync_a` OR `sync_b`. A qualification count rises by one on each selected `word_clk` edge while the request is high, and it saturates at 5. While the count is below 5, frames carry data.
- R5: A frame that loads while the request is high and the count is 5 is the sync pattern 12'b000000111111: six 1s are sent first, then six 0s.
- R6: Sync frames follow each other back to back while the request stays high.
- R7: A sync frame already started is sent in full even if the request drops during it. The next frame carries data.
- R8: A low combined request clears the count at once. Five new selected edges are then needed before another sync frame is sent.
- R9: With `out_en` low, `drive_en` is 0 and `ser_out` is 0. Frames keep advancing underneath.
- R10: With `pwr_n` low, `drive_en` and `ser_out` are 0. The stored word is cleared to 0, the count is cleared, and the frame position restarts. Edges and `bit_en` pulses have no effect while powered down.
- R11: After reset, `drive_en` and `ser_out` stay 0 until the first frame loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| word_clk | input | 1 | Word-rate transmit clock, sampled |
| edge_sel | input | 1 | 1 = capture on rising edge, 0 = on falling edge |
| din | input | 10 | Parallel data word |
| sync_a | input | 1 | Sync request, first source |
| sync_b | input | 1 | Sync request, second source |
| out_en | input | 1 | Output enable |
| pwr_n | input | 1 | Active-low powerdown |
| bit_en | input | 1 | Bit-rate enable, one pulse per serial bit |
| ser_out | output | 1 | Serial data bit, 0 when not driven |
| drive_en | output | 1 | Output driven and valid |

## Verification
The hardest case to reach is a sync request that drops partway through a sync frame. Reaching it means building a count of exactly five selected edges and then dropping the request at a chosen bit inside the frame. The stimulus counts selected edges one by one with a helper that forces the opposite level first, so it creates only one qualifying edge at a time. The frame collector takes a bit index at which it releases the request. Runs of four edges interrupted by a one-cycle drop show that the count clears at once and does not pause.

// File: rtl/ser10_pkg.sv
package ser10_pkg;

    localparam int DATA_W  = 10;
    localparam int FRAME_W = DATA_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    typedef enum logic {
        FRM_DATA = 1'b0,
        FRM_SYNC = 1'b1
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e          kind;
        logic [FRAME_W-1:0]   bits;
    } frame_t;

    // bit 0 leaves first: lead 1, data LSB first, trail 0
    function automatic logic [FRAME_W-1:0] data_frame(input logic [DATA_W-1:0] w);
        return {1'b0, w, 1'b1};
    endfunction

    // first half ones, second half zeros
    function automatic logic [FRAME_W-1:0] sync_frame();
        logic [FRAME_W-1:0] f;
        f = '0;
        for (int i = 0; i < FRAME_W / 2; i++) begin
            f[i] = 1'b1;
        end
        return f;
    endfunction

endpackage

// File: rtl/ser10_capture.sv
module ser10_capture
    import ser10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_n,
    input  logic              word_clk,
    input  logic              edge_sel,
    input  logic [DATA_W-1:0] din,
    output logic              strobe,
    output logic [DATA_W-1:0] hold
);

    logic wclk_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            wclk_q <= word_clk;
        end else begin
            wclk_q <= word_clk;
        end
    end

    assign rise   = word_clk & ~wclk_q;
    assign fall   = ~word_clk & wclk_q;
    assign strobe = pwr_n & (edge_sel ? rise : fall);

    always_ff @(posedge clk) begin
        if (rst || !pwr_n) begin
            hold <= '0;
        end else if (strobe) begin
            hold <= din;
        end
    end

    // R1
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst || !pwr_n)
        (!strobe) |=> $stable(hold));

endmodule

// File: rtl/ser10_syncq.sv
module ser10_syncq #(
    parameter int SYNC_MIN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_n,
    input  logic req_a,
    input  logic req_b,
    input  logic strobe,
    output logic qualified
);

    localparam int CNT_W = $clog2(SYNC_MIN + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SYNC_MIN);

    logic             req_any;
    logic [CNT_W-1:0] cnt;

    assign req_any = req_a | req_b;

    always_ff @(posedge clk) begin
        if (rst || !pwr_n) begin
            cnt <= '0;
        end else if (!req_any) begin
            cnt <= '0;
        end else if (strobe && cnt != CNT_TOP) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign qualified = req_any && (cnt == CNT_TOP);

    // R4
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_TOP);

    // R8
    req_drop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_any) |=> (cnt == '0));

endmodule

// File: rtl/ser10_shifter.sv
module ser10_shifter
    import ser10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_n,
    input  logic              bit_en,
    input  logic [DATA_W-1:0] hold,
    input  logic              qualified,
    output logic              ser_bit,
    output logic              active
);

    logic [IDX_W-1:0]   idx;
    logic [FRAME_W-1:0] shreg;
    frame_kind_e        kind_q;
    frame_t             nxt;
    logic               at_last;

    assign at_last = (idx == LAST_IDX);

    always_comb begin
        if (qualified) begin
            nxt.kind = FRM_SYNC;
            nxt.bits = sync_frame();
        end else begin
            nxt.kind = FRM_DATA;
            nxt.bits = data_frame(hold);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_n) begin
            idx    <= LAST_IDX;
            shreg  <= '0;
            kind_q <= FRM_DATA;
            active <= 1'b0;
        end else if (bit_en) begin
            if (at_last) begin
                shreg  <= nxt.bits;
                kind_q <= nxt.kind;
                idx    <= '0;
                active <= 1'b1;
            end else begin
                shreg <= shreg >> 1;
                idx   <= idx + IDX_W'(1);
            end
        end
    end

    assign ser_bit = shreg[0];

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        idx <= LAST_IDX);

    // R2
    frame_lead_chk: assert property (@(posedge clk) disable iff (rst || !pwr_n)
        (bit_en && at_last) |=> ser_bit);

    // R7
    sync_whole_chk: assert property (@(posedge clk) disable iff (rst || !pwr_n)
        (kind_q == FRM_SYNC && !at_last) |=> (kind_q == FRM_SYNC));

endmodule

// File: rtl/ser10_tx.sv
module ser10_tx #(
    parameter int SYNC_MIN = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        word_clk,
    input  logic                        edge_sel,
    input  logic [ser10_pkg::DATA_W-1:0] din,
    input  logic                        sync_a,
    input  logic                        sync_b,
    input  logic                        out_en,
    input  logic                        pwr_n,
    input  logic                        bit_en,
    output logic                        ser_out,
    output logic                        drive_en
);

    import ser10_pkg::*;

    logic              strobe;
    logic [DATA_W-1:0] hold;
    logic              qualified;
    logic              ser_bit;
    logic              active;

    ser10_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .pwr_n    (pwr_n),
        .word_clk (word_clk),
        .edge_sel (edge_sel),
        .din      (din),
        .strobe   (strobe),
        .hold     (hold)
    );

    ser10_syncq #(.SYNC_MIN(SYNC_MIN)) u_syncq (
        .clk       (clk),
        .rst       (rst),
        .pwr_n     (pwr_n),
        .req_a     (sync_a),
        .req_b     (sync_b),
        .strobe    (strobe),
        .qualified (qualified)
    );

    ser10_shifter u_shifter (
        .clk       (clk),
        .rst       (rst),
        .pwr_n     (pwr_n),
        .bit_en    (bit_en),
        .hold      (hold),
        .qualified (qualified),
        .ser_bit   (ser_bit),
        .active    (active)
    );

    assign drive_en = out_en & pwr_n & active;
    assign ser_out  = drive_en & ser_bit;

    // R10
    pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!pwr_n) |-> (!drive_en && !ser_out));

    // R9
    oe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_en) |-> (!ser_out));

endmodule

// File: tb/test_ser10_tx.sv
module test_ser10_tx;

    logic       clk = 1'b0;
    logic       rst;
    logic       word_clk, edge_sel, sync_a, sync_b, out_en, pwr_n, bit_en;
    logic [9:0] din;
    logic       ser_out, drive_en;

    int errs   = 0;
    int checks = 0;

    always #5 clk = ~clk;

    ser10_tx i_ser10_tx (
        .clk      (clk),
        .rst      (rst),
        .word_clk (word_clk),
        .edge_sel (edge_sel),
        .din      (din),
        .sync_a   (sync_a),
        .sync_b   (sync_b),
        .out_en   (out_en),
        .pwr_n    (pwr_n),
        .bit_en   (bit_en),
        .ser_out  (ser_out),
        .drive_en (drive_en)
    );

    localparam logic [11:0] SYNC_PAT = 12'h03F;

    // {edge_sel, mode(1 = wrong edge only), data, expected word}
    localparam logic [21:0] VEC [8] = '{
        {1'b1, 1'b0, 10'h2A5, 10'h2A5},
        {1'b1, 1'b1, 10'h0F0, 10'h2A5},
        {1'b0, 1'b0, 10'h3FF, 10'h3FF},
        {1'b0, 1'b1, 10'h001, 10'h3FF},
        {1'b0, 1'b0, 10'h200, 10'h200},
        {1'b1, 1'b0, 10'h155, 10'h155},
        {1'b1, 1'b1, 10'h000, 10'h155},
        {1'b0, 1'b0, 10'h0C3, 10'h0C3}
    };

    function automatic logic [11:0] dframe(input logic [9:0] w);
        return {1'b0, w, 1'b1};
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wset(input logic lvl);
        @(negedge clk);
        word_clk = lvl;
    endtask

    task automatic sel_edge();
        if (word_clk == edge_sel) wset(~edge_sel);
        wset(edge_sel);
    endtask

    task automatic pulse_bit(output logic b);
        @(negedge clk);
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        b = ser_out;
    endtask

    task automatic get_frame(input int drop_at, output logic [11:0] f);
        logic b;
        for (int i = 0; i < 12; i++) begin
            if (i == drop_at) begin
                sync_a = 1'b0;
                sync_b = 1'b0;
            end
            pulse_bit(b);
            f[i] = b;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [11:0] f;
        logic        b;

        rst = 1'b1; word_clk = 1'b0; edge_sel = 1'b1; din = '0;
        sync_a = 1'b0; sync_b = 1'b0; out_en = 1'b1; pwr_n = 1'b1; bit_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 drive_en in reset", drive_en, 0);
        chk("R11 ser_out in reset", ser_out, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 drive_en before first frame", drive_en, 0);

        // vector table: capture edge and frame format
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            edge_sel = VEC[v][21];
            if (!VEC[v][20]) begin
                if (word_clk == edge_sel) wset(~edge_sel);
                @(negedge clk);
                din = VEC[v][19:10];
                word_clk = edge_sel;
            end else begin
                if (word_clk != edge_sel) wset(edge_sel);
                @(negedge clk);
                din = VEC[v][19:10];
                word_clk = ~edge_sel;
            end
            @(negedge clk);
            get_frame(-1, f);
            chk($sformatf("R1 R2 R3 vector %0d frame", v), f, dframe(VEC[v][9:0]));
            if (v == 0) chk("R11 drive_en after first load", drive_en, 1);
        end

        // sync qualification through sync_a
        @(negedge clk);
        din = 10'h111;
        repeat (4) sel_edge();
        @(negedge clk);
        sync_a = 1'b1;
        repeat (4) sel_edge();
        get_frame(-1, f);
        chk("R4 four edges still data", f, dframe(10'h111));
        sel_edge();
        get_frame(-1, f);
        chk("R5 sync pattern after five edges", f, SYNC_PAT);
        get_frame(-1, f);
        chk("R6 sync repeats while held", f, SYNC_PAT);
        get_frame(6, f);
        chk("R7 sync frame sent whole after drop", f, SYNC_PAT);
        get_frame(-1, f);
        chk("R7 data resumes after sync", f, dframe(10'h111));

        // immediate clear, then sync_b path
        @(negedge clk);
        sync_b = 1'b1;
        repeat (4) sel_edge();
        @(negedge clk);
        sync_b = 1'b0;
        @(negedge clk);
        sync_b = 1'b1;
        sel_edge();
        get_frame(-1, f);
        chk("R8 count cleared by one-cycle drop", f, dframe(10'h111));
        repeat (4) sel_edge();
        get_frame(-1, f);
        chk("R4 sync_b qualifies after five edges", f, SYNC_PAT);
        @(negedge clk);
        sync_b = 1'b0;
        get_frame(-1, f);
        chk("R8 drop before frame gives data", f, dframe(10'h111));

        // output enable
        @(negedge clk);
        out_en = 1'b0;
        get_frame(-1, f);
        chk("R9 ser_out held low", f, 12'h000);
        chk("R9 drive_en low", drive_en, 0);
        @(negedge clk);
        out_en = 1'b1;
        get_frame(-1, f);
        chk("R9 frames continue after enable", f, dframe(10'h111));

        // powerdown mid-frame
        @(negedge clk);
        din = 10'h2C7;
        sel_edge();
        for (int i = 0; i < 5; i++) pulse_bit(b);
        @(negedge clk);
        pwr_n = 1'b0;
        @(negedge clk);
        chk("R10 drive_en low in powerdown", drive_en, 0);
        chk("R10 ser_out low in powerdown", ser_out, 0);
        sync_a = 1'b1;
        din = 10'h155;
        repeat (5) sel_edge();
        pulse_bit(b);
        chk("R10 bit_en ignored in powerdown", b, 0);
        @(negedge clk);
        sync_a = 1'b0;
        pwr_n = 1'b1;
        @(negedge clk);
        get_frame(-1, f);
        chk("R10 word cleared, frame restarts", f, dframe(10'h000));
        sel_edge();
        get_frame(-1, f);
        chk("R1 capture works after powerdown", f, dframe(10'h155));

        report();
        $finish;
    end

endmodule